// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Low-Power Entry

This block sends 8-bit words over a clocked serial link, least significant bit first. Software loads a byte into a holding register and releases it through a status handshake. The block then copies the byte into a shift register and sends one bit per serial clock. The serial clock comes either from an internal divider or from an external clock pin. Two interrupt lines and a one-cycle transfer-request strobe let software or a transfer engine feed the next byte. When the holding register is released while a frame is still going out, the next frame follows without a gap.

An active low-power request clears the holding register, the shift register and the status flags. It also clears the three enables, abandons any frame in flight and parks the data pin high. In external clock mode, serial clock edges that arrive shortly after a holding-register write are ignored. This keeps a freshly written byte from being disturbed by an early clock edge.

Register map. Address 0 is control:
- bit0: transmit enable
- bit1: empty-interrupt enable
- bit2: end-interrupt enable
- bit3: external clock select

Address 1 is status:
- bit7: holding register empty
- bit6: transmission end

Address 2 is the holding register. Reads of any other bits return 0.

Top module: `sst_tx`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xC0, the holding register reads 0x00, `txd` and `sclk_out` are 1, and both interrupt outputs are 0.
- R2: With the internal clock (control bit3 = 0), a frame sends holding-register bits 0 through 7 in that order. `txd` changes on the same clock as each 1-to-0 transition of `sclk_out`. `sclk_out` makes exactly 8 low pulses of `HALF_DIV` cycles each and otherwise stays at 1. `txd` is 1 whenever no frame is active.
- R3: The empty flag (status bit7) is cleared only by a status write with bit7 = 0. That write must follow a status read that returned bit7 = 1. A clearing write with no such read leaves status bit7 at 1 and starts no frame.
- R4: Copying the holding register into the shift register sets status bit7 again. `irq_empty` equals transmit enable AND empty-interrupt enable AND status bit7. `xfer_req` pulses high for exactly one cycle each time `irq_empty` rises.
- R5: Status bit6 is cleared when a frame is loaded. It is set after the eighth bit completes if status bit7 is still 1. `irq_end` equals end-interrupt enable AND status bit6.
- R6: If status bit7 has been cleared again before a frame ends, the next frame starts right after it, and status bit6 stays 0 between the two frames.
- R7: With the external clock (control bit3 = 1), each falling edge of `sclk_in` puts the next bit on `txd` and the following rising edge completes it. `sclk_out` stays 1 in this mode.
- R8: In external mode, `sclk_in` edges seen within `GUARD_CYC` system clocks after a holding-register write are ignored. A frame waiting for its first clock therefore keeps `txd` at 1.
- R9: While `lp_req` is 1, the block does the following:
  - clears the holding register and control bits 0..2;
  - sets status to 0xC0;
  - abandons any frame in progress and never resumes it;
  - drives `txd` and `sclk_out` to 1;
  - ignores register writes.
- R10: With transmit enable at 0, a released byte is not loaded and no serial clock runs. The byte is sent once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Low-power mode request, level |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internal serial clock, idles high |
| txd | output | 1 | Serial data out |
| irq_empty | output | 1 | Holding-register-empty interrupt |
| irq_end | output | 1 | Transmission-end interrupt |
| xfer_req | output | 1 | One-cycle transfer-engine trigger |

## Verification
The shift path is driven with the bytes 0xA5, 0x3C, 0xC3, 0x96, 0x5A and 0x81. Together they set both end bits to each value and include alternating and half-swapped patterns, so a reversed bit order, an off-by-one shift or a stuck bit produces a wrong captured byte. Two bytes are queued back to back and captured as one 16-bit stream; this separates a correct reload from a dropped or repeated frame. The external-clock run first applies an early clock edge right after a data write and then eight clean pulses. This shows whether the guard window suppresses the edge or the frame starts too soon. A low-power request in mid-frame followed by 100 idle cycles shows whether the frame is truly abandoned.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int FRAME_BITS = 8;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2
    } sst_addr_e;

    // packed so that tx_en sits at bit0 and ext_clk at bit3
    typedef struct packed {
        logic ext_clk;
        logic end_ie;
        logic empty_ie;
        logic tx_en;
    } sst_ctrl_t;

    typedef struct packed {
        logic empty;
        logic done;
    } sst_stat_t;

    function automatic logic [7:0] ctrl_byte(input sst_ctrl_t c);
        return {4'b0000, c};
    endfunction

    function automatic logic [7:0] stat_byte(input sst_stat_t s);
        return {s.empty, s.done, 6'b000000};
    endfunction

endpackage

// File: rtl/sst_regs.sv
module sst_regs
    import sst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lp_req,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [1:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  load,
    input  logic                  frame_end,
    output sst_ctrl_t             ctrl,
    output logic [FRAME_BITS-1:0] hold_data,
    output logic                  pending,
    output logic                  data_wr,
    output logic                  irq_empty,
    output logic                  irq_end,
    output logic                  xfer_req
);

    sst_ctrl_t             ctrl_q;
    sst_stat_t             stat_q;
    logic [FRAME_BITS-1:0] data_q;
    logic                  armed_q;
    logic                  req_q;
    sst_addr_e             addr;

    assign addr    = sst_addr_e'(bus_addr);
    assign data_wr = bus_wr && !lp_req && (addr == A_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= '{empty: 1'b1, done: 1'b1};
            data_q  <= '0;
            armed_q <= 1'b0;
        end else if (lp_req) begin
            ctrl_q.tx_en    <= 1'b0;
            ctrl_q.empty_ie <= 1'b0;
            ctrl_q.end_ie   <= 1'b0;
            stat_q          <= '{empty: 1'b1, done: 1'b1};
            data_q          <= '0;
            armed_q         <= 1'b0;
        end else begin
            if (bus_wr && addr == A_CTRL)
                ctrl_q <= sst_ctrl_t'(bus_wdata[3:0]);
            if (data_wr)
                data_q <= bus_wdata;
            if (bus_rd && addr == A_STAT && stat_q.empty)
                armed_q <= 1'b1;
            if (bus_wr && addr == A_STAT && armed_q && !bus_wdata[7]) begin
                stat_q.empty <= 1'b0;
                armed_q      <= 1'b0;
            end
            if (load) begin
                stat_q.empty <= 1'b1;
                stat_q.done  <= 1'b0;
            end else if (frame_end && stat_q.empty) begin
                stat_q.done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= irq_empty;
    end

    always_comb begin
        case (addr)
            A_CTRL:  bus_rdata = ctrl_byte(ctrl_q);
            A_STAT:  bus_rdata = stat_byte(stat_q);
            A_DATA:  bus_rdata = data_q;
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl      = ctrl_q;
    assign hold_data = data_q;
    assign pending   = !stat_q.empty;
    assign irq_empty = ctrl_q.tx_en && ctrl_q.empty_ie && stat_q.empty;
    assign irq_end   = ctrl_q.end_ie && stat_q.done;
    assign xfer_req  = irq_empty && !req_q;

    // R4
    load_sets_empty_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> stat_q.empty);

    // R9
    lp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        lp_req |=> (stat_q.empty && stat_q.done && !ctrl_q.tx_en &&
                    !ctrl_q.empty_ie && !ctrl_q.end_ie && data_q == '0));

    // R4
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |=> !xfer_req);

endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_p,
    output logic rise_p
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          tick;

    assign tick   = run && (cnt_q == LAST);
    assign fall_p = tick && sclk_q;
    assign rise_p = tick && !sclk_q;
    assign sclk   = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    stopped_high_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> sclk_q);

endmodule

// File: rtl/sst_extclk.sv
module sst_extclk #(
    parameter int SYNC_STAGES = 2,
    parameter int GUARD_CYC   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_req,
    input  logic enable,
    input  logic sclk_in,
    input  logic data_wr,
    output logic fall_p,
    output logic rise_p
);

    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_CYC);

    logic [SYNC_STAGES:0] chain_q;
    logic [GW-1:0]        guard_q;
    logic                 cur, prev, open_win;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], sclk_in};
    end

    always_ff @(posedge clk) begin
        if (rst || lp_req)       guard_q <= '0;
        else if (data_wr)        guard_q <= GUARD_LOAD;
        else if (guard_q != '0)  guard_q <= guard_q - 1'b1;
    end

    assign cur      = chain_q[SYNC_STAGES-1];
    assign prev     = chain_q[SYNC_STAGES];
    assign open_win = enable && (guard_q == '0);
    assign fall_p   = open_win && prev && !cur;
    assign rise_p   = open_win && !prev && cur;

    // R8
    guard_block_chk: assert property (@(posedge clk) disable iff (rst)
        (guard_q != '0) |-> !(fall_p || rise_p));

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lp_req,
    input  logic                  start_ok,
    input  logic [FRAME_BITS-1:0] data_in,
    input  logic                  fall_p,
    input  logic                  rise_p,
    output logic                  txd,
    output logic                  active,
    output logic                  load,
    output logic                  frame_end
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic                  active_q, driven_q, txd_q;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] sh_q;

    assign frame_end = active_q && driven_q && rise_p && (idx_q == LAST_IDX);
    assign load      = !lp_req && start_ok && (!active_q || frame_end);

    always_ff @(posedge clk) begin
        if (rst || lp_req) begin
            active_q <= 1'b0;
            driven_q <= 1'b0;
            idx_q    <= '0;
            sh_q     <= '0;
            txd_q    <= 1'b1;
        end else if (load) begin
            active_q <= 1'b1;
            driven_q <= 1'b0;
            idx_q    <= '0;
            sh_q     <= data_in;
            txd_q    <= 1'b1;
        end else if (frame_end) begin
            active_q <= 1'b0;
            driven_q <= 1'b0;
            txd_q    <= 1'b1;
        end else if (active_q) begin
            if (fall_p && !driven_q) begin
                txd_q    <= sh_q[0];
                sh_q     <= {1'b0, sh_q[FRAME_BITS-1:1]};
                driven_q <= 1'b1;
            end else if (rise_p && driven_q) begin
                driven_q <= 1'b0;
                idx_q    <= idx_q + 1'b1;
            end
        end
    end

    assign txd    = txd_q;
    assign active = active_q;

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> txd_q);

    // R5
    frame_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !load) |=> !active_q);

endmodule

// File: rtl/sst_tx.sv
module sst_tx
    import sst_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int GUARD_CYC   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_req,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       txd,
    output logic       irq_empty,
    output logic       irq_end,
    output logic       xfer_req
);

    sst_ctrl_t             ctrl;
    logic [FRAME_BITS-1:0] hold_data;
    logic                  pending, data_wr, load, frame_end, active;
    logic                  int_sclk, int_fall, int_rise;
    logic                  ext_fall, ext_rise;
    logic                  fall_p, rise_p;

    sst_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .lp_req    (lp_req),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .load      (load),
        .frame_end (frame_end),
        .ctrl      (ctrl),
        .hold_data (hold_data),
        .pending   (pending),
        .data_wr   (data_wr),
        .irq_empty (irq_empty),
        .irq_end   (irq_end),
        .xfer_req  (xfer_req)
    );

    sst_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run    (active && !ctrl.ext_clk && !lp_req),
        .sclk   (int_sclk),
        .fall_p (int_fall),
        .rise_p (int_rise)
    );

    sst_extclk #(.SYNC_STAGES(SYNC_STAGES), .GUARD_CYC(GUARD_CYC)) u_extclk (
        .clk     (clk),
        .rst     (rst),
        .lp_req  (lp_req),
        .enable  (ctrl.ext_clk),
        .sclk_in (sclk_in),
        .data_wr (data_wr),
        .fall_p  (ext_fall),
        .rise_p  (ext_rise)
    );

    assign fall_p   = ctrl.ext_clk ? ext_fall : int_fall;
    assign rise_p   = ctrl.ext_clk ? ext_rise : int_rise;
    assign sclk_out = ctrl.ext_clk ? 1'b1 : int_sclk;

    sst_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .lp_req    (lp_req),
        .start_ok  (ctrl.tx_en && pending),
        .data_in   (hold_data),
        .fall_p    (fall_p),
        .rise_p    (rise_p),
        .txd       (txd),
        .active    (active),
        .load      (load),
        .frame_end (frame_end)
    );

endmodule

// File: tb/sst_tx_tb.sv
module sst_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_req = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_in = 1'b1;
    logic       sclk_out, txd, irq_empty, irq_end, xfer_req;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sst_tx dut_i (
        .clk(clk), .rst(rst), .lp_req(lp_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .txd(txd),
        .irq_empty(irq_empty), .irq_end(irq_end), .xfer_req(xfer_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic capture(input int nbits, output logic [15:0] bits);
        int n = 0;
        int t = 0;
        logic prev;
        bits = '0;
        prev = sclk_out;
        while (n < nbits && t < 3000) begin
            @(negedge clk);
            t++;
            if (prev && !sclk_out) begin
                bits[n] = txd;
                n++;
            end
            prev = sclk_out;
        end
        if (n < nbits) check("R2 capture timeout", n, nbits);
    endtask

    task automatic ext_pulse(output logic b);
        sclk_in = 1'b0;
        repeat (5) @(negedge clk);
        b = txd;
        sclk_in = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd2, v); check("R1 data", v, 8'h00);
        check("R1 txd", txd, 1'b1);
        check("R1 sclk_out", sclk_out, 1'b1);
        check("R1 irqs", {irq_empty, irq_end}, 2'b00);
    endtask

    task automatic t_internal();
        logic [7:0]  v;
        logic [15:0] bits;
        int toggles = 0;
        wr(2'd0, 8'h07);
        check("R4 xfer_req pulse", xfer_req, 1'b1);
        check("R4 irq_empty", irq_empty, 1'b1);
        @(negedge clk);
        check("R4 xfer_req one cycle", xfer_req, 1'b0);
        wr(2'd2, 8'hA5);
        wr(2'd1, 8'h00);            // no prior status read
        repeat (20) begin
            @(negedge clk);
            if (!sclk_out) toggles++;
        end
        check("R3 no start without read", toggles, 0);
        rd(2'd1, v); check("R3 status unchanged / R1 status", v, 8'hC0);
        fork
            wr(2'd1, 8'h00);
            capture(8, bits);
        join
        check("R2 frame 0xA5", bits[7:0], 8'hA5);
        repeat (10) @(negedge clk);
        rd(2'd1, v); check("R5 end flag set", v, 8'hC0);
        check("R5 irq_end", irq_end, 1'b1);
        check("R2 idle levels", {txd, sclk_out}, 2'b11);
    endtask

    task automatic t_back2back();
        logic [7:0]  v;
        logic [15:0] bits;
        rd(2'd1, v);
        wr(2'd2, 8'h3C);
        fork
            capture(16, bits);
            begin
                wr(2'd1, 8'h00);
                repeat (3) @(negedge clk);
                check("R5 end cleared on load", irq_end, 1'b0);
                rd(2'd1, v);
                check("R4 empty after load", v, 8'h80);
                wr(2'd2, 8'hC3);
                wr(2'd1, 8'h00);
            end
        join
        check("R6 two frames", bits, 16'hC33C);
        repeat (10) @(negedge clk);
        rd(2'd1, v); check("R6 end after second", v, 8'hC0);
    endtask

    task automatic t_te_off();
        logic [7:0]  v;
        logic [15:0] bits;
        int toggles = 0;
        wr(2'd0, 8'h06);
        check("R10 irq_empty off", irq_empty, 1'b0);
        rd(2'd1, v);
        wr(2'd2, 8'h5A);
        wr(2'd1, 8'h00);
        repeat (30) begin
            @(negedge clk);
            if (!sclk_out || !txd) toggles++;
        end
        check("R10 idle with enable off", toggles, 0);
        rd(2'd1, v); check("R10 byte still held", v, 8'h40);
        fork
            wr(2'd0, 8'h07);
            capture(8, bits);
        join
        check("R10 sent after enable", bits[7:0], 8'h5A);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        logic [7:0] got;
        logic       b;
        int         sc = 0;
        wr(2'd0, 8'h08);
        rd(2'd1, v);
        wr(2'd2, 8'h96);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h09);           // enable: frame loads, waits for clock
        wr(2'd2, 8'hFF);           // restarts guard window
        sclk_in = 1'b0;            // early edge inside window
        repeat (4) @(negedge clk);
        check("R8 early edge ignored", txd, 1'b1);
        sclk_in = 1'b1;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ext_pulse(b);
            got[i] = b;
            if (!sclk_out) sc++;
        end
        check("R7 external frame 0x96", got, 8'h96);
        check("R7 sclk_out held high", sc, 0);
        rd(2'd1, v); check("R7 end after external frame", v, 8'hC0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_lp();
        logic [7:0]  v;
        logic [15:0] bits;
        int toggles = 0;
        wr(2'd0, 8'h07);
        rd(2'd1, v);
        wr(2'd2, 8'h5A);
        wr(2'd1, 8'h00);
        repeat (20) @(negedge clk);
        lp_req = 1'b1;
        wr(2'd0, 8'h07);           // ignored while low-power request
        wr(2'd2, 8'h77);
        lp_req = 1'b0;
        rd(2'd0, v); check("R9 ctrl cleared", v, 8'h00);
        rd(2'd1, v); check("R9 status reset", v, 8'hC0);
        rd(2'd2, v); check("R9 data cleared", v, 8'h00);
        check("R9 irq off", irq_empty, 1'b0);
        repeat (100) begin
            @(negedge clk);
            if (!sclk_out || !txd) toggles++;
        end
        check("R9 frame abandoned, pins high", toggles, 0);
        wr(2'd0, 8'h07);
        rd(2'd1, v);
        wr(2'd2, 8'h81);
        fork
            wr(2'd1, 8'h00);
            capture(8, bits);
        join
        check("R9 restart frame", bits[7:0], 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_internal();
        t_back2back();
        t_te_off();
        t_ext();
        t_lp();
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule